// File: doc/BRIEF.md
# Deep Power-Down Wake Timer Controller

This block is the always-on wake logic that keeps running while the rest of the device sits in deep power-down. It is clocked by the slow 10 kHz oscillator domain. An entry strobe starts a sleep period. The block can end that period in two ways. One is a programmable interval of 64 x (setting + 1) slow ticks, so each setting step adds 6.4 ms. The other is a falling edge on an external wake pin. When the period ends, the block raises a sticky wake request and records the cause in flags.

At entry the block captures several values and holds them for the whole sleep period. It copies the interval setting into a readback field. It freezes the wake-pin pull-up choice. It captures the arm conditions for the timer and the pin. It clears the cause flags. A power-on reset sets the power-on cause flag, which stays set until the next entry. All pins are plain control and status levels. The block has no data stream, so no handshake is needed.

Top module: `dpd_wake_ctrl`

## Requirements
- R1: After reset, `wake_req` = 0, `dpd_asleep` = 0, `flag_pin` = 0, `flag_timer` = 0, `flag_por` = 1, `setting_rb` = 0 and `pullup_off` = 1 (tri-state).
- R2: On a clock edge where `dpd_enter` = 1, the block clears all three cause flags and `wake_req`, sets `dpd_asleep`, and loads `setting_rb` with `wake_setting`. Later changes of `wake_setting` do not change `setting_rb` until the next entry.
- R3: With the timer armed, `wake_req` rises exactly 64 x (N + 1) clock edges after the entry edge, where N is the captured setting. At that point `flag_timer` = 1 and `dpd_asleep` = 0.
- R4: The timer is armed only when, at entry, `timer_wake_en` = 1 and `osc_off_in_dpd` = 0. When it is not armed, the interval never causes a wake.
- R5: The pin is armed only when `pin_wake_dis` = 0 at entry (active-low enable). A high-to-low transition of `wake_pin` then raises `wake_req` and `flag_pin` on the third clock edge after the change, because it passes a two-flop synchronizer and an edge register.
- R6: With `pin_wake_dis` = 1 at entry, falling edges on `wake_pin` have no effect. A pin already low or held low produces no wake, since only transitions count.
- R7: If the timer and the pin fire on the same edge, both `flag_timer` and `flag_pin` are set, and a single wake request is issued.
- R8: Once `wake_req` is high, it stays high until the next `dpd_enter` edge or reset.
- R9: `pullup_off` takes the value of `pullup_sel_n` on the entry edge and holds it until the next entry. A value of 0 means the pull-up is on; 1 means the pin is tri-stated.
- R10: `flag_por` is set only by reset and is cleared by entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow always-on clock (10 kHz domain) |
| rst_n | input | 1 | Active-low power-on reset, asynchronous |
| dpd_enter | input | 1 | One-cycle strobe that starts deep power-down |
| wake_setting | input | 14 | Interval setting N |
| timer_wake_en | input | 1 | 1 allows timer wake |
| osc_off_in_dpd | input | 1 | 1 means the slow oscillator is off in power-down, which blocks timer wake |
| pin_wake_dis | input | 1 | 0 allows pin wake; 1 blocks it |
| wake_pin | input | 1 | Asynchronous wake pin; a falling edge wakes the device |
| pullup_sel_n | input | 1 | Pull-up request: 0 = pull-up on, 1 = tri-state |
| wake_req | output | 1 | Sticky wake request |
| dpd_asleep | output | 1 | High from entry until wake |
| flag_pin | output | 1 | The wake was caused by the pin |
| flag_timer | output | 1 | The wake was caused by the timer |
| flag_por | output | 1 | The wake was caused by power-on reset |
| setting_rb | output | 14 | Setting captured at entry |
| pullup_off | output | 1 | Latched pull-up control |

## Verification
The hardest case to reach from the ports is a pin edge and a timer expiry landing on the same clock edge. To force it, the bench uses the smallest interval (N = 0, expiry 64 edges after entry). It then drops the pin right after edge 61, so that the synchronizer delay makes the edge detection mature on edge 64. The bench also checks the timer boundary one cycle early and on the exact cycle. It checks that a pin still held low from the previous wake cannot wake the device again.

// File: rtl/dpdw_pkg.sv
package dpdw_pkg;
  // Width of the interval setting and of the tick counter
  localparam int unsigned SET_W   = 14;
  // Prescaler width: the prescaler wraps every 2**PRE_W slow ticks
  localparam int unsigned PRE_W   = 6;
  // Synchronizer depth for the wake pin
  localparam int unsigned SYNC_N  = 2;

  typedef struct packed {
    logic timer_arm;
    logic pin_arm;
    logic pull_off;
  } dpdw_cfg_t;
endpackage

// File: rtl/dpdw_pin_sync.sv
module dpdw_pin_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_async,
  output logic pin_fall
);
  logic [STAGES-1:0] chain;
  logic              prev;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= 1'b1;
          else        chain[0] <= pin_async;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[g] <= 1'b1;
          else        chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= 1'b1;
    else        prev <= chain[STAGES-1];
  end

  // High for one cycle after a synchronized high-to-low transition
  assign pin_fall = prev & ~chain[STAGES-1];
endmodule

// File: rtl/dpdw_interval.sv
module dpdw_interval #(
  parameter int unsigned SET_W = 14,
  parameter int unsigned PRE_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             run,
  input  logic [SET_W-1:0] limit,
  output logic             hit
);
  localparam logic [PRE_W-1:0] PRE_LAST = {PRE_W{1'b1}};

  logic [PRE_W-1:0] pre_q;
  logic [SET_W-1:0] tick_q;
  logic             pre_wrap;

  assign pre_wrap = (pre_q == PRE_LAST);
  assign hit      = run && pre_wrap && (tick_q == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q  <= '0;
      tick_q <= '0;
    end else if (restart) begin
      pre_q  <= '0;
      tick_q <= '0;
    end else if (run) begin
      pre_q <= pre_q + 1'b1;
      if (pre_wrap && !hit) tick_q <= tick_q + 1'b1;
    end
  end
endmodule

// File: rtl/dpdw_state.sv
module dpdw_state
  import dpdw_pkg::*;
#(
  parameter int unsigned SET_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enter,
  input  logic [SET_W-1:0] setting,
  input  dpdw_cfg_t        cfg_in,
  input  logic             timer_hit,
  input  logic             pin_fall,
  output logic             asleep,
  output logic             wake,
  output logic             f_pin,
  output logic             f_tmr,
  output logic             f_por,
  output logic [SET_W-1:0] rb,
  output dpdw_cfg_t        cfg_q
);
  logic pin_hit;
  logic tmr_hit;

  assign pin_hit = asleep && cfg_q.pin_arm && pin_fall;
  assign tmr_hit = asleep && timer_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      asleep <= 1'b0;
      wake   <= 1'b0;
      f_pin  <= 1'b0;
      f_tmr  <= 1'b0;
      f_por  <= 1'b1;
      rb     <= '0;
      cfg_q  <= '{timer_arm: 1'b0, pin_arm: 1'b0, pull_off: 1'b1};
    end else if (enter) begin
      asleep <= 1'b1;
      wake   <= 1'b0;
      f_pin  <= 1'b0;
      f_tmr  <= 1'b0;
      f_por  <= 1'b0;
      rb     <= setting;
      cfg_q  <= cfg_in;
    end else if (pin_hit || tmr_hit) begin
      asleep <= 1'b0;
      wake   <= 1'b1;
      f_pin  <= pin_hit;
      f_tmr  <= tmr_hit;
    end
  end
endmodule

// File: rtl/dpd_wake_ctrl.sv
module dpd_wake_ctrl
  import dpdw_pkg::*;
#(
  parameter int unsigned W_SET = SET_W,
  parameter int unsigned W_PRE = PRE_W,
  parameter int unsigned N_SYNC = SYNC_N
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dpd_enter,
  input  logic [W_SET-1:0] wake_setting,
  input  logic             timer_wake_en,
  input  logic             osc_off_in_dpd,
  input  logic             pin_wake_dis,
  input  logic             wake_pin,
  input  logic             pullup_sel_n,
  output logic             wake_req,
  output logic             dpd_asleep,
  output logic             flag_pin,
  output logic             flag_timer,
  output logic             flag_por,
  output logic [W_SET-1:0] setting_rb,
  output logic             pullup_off
);
  dpdw_cfg_t cfg_next;
  dpdw_cfg_t cfg_cur;
  logic      fall;
  logic      t_hit;
  logic      t_run;

  assign cfg_next.timer_arm = timer_wake_en & ~osc_off_in_dpd;
  assign cfg_next.pin_arm   = ~pin_wake_dis;
  assign cfg_next.pull_off  = pullup_sel_n;

  assign t_run = dpd_asleep && !wake_req && cfg_cur.timer_arm;

  dpdw_pin_sync #(.STAGES(N_SYNC)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .pin_async (wake_pin),
    .pin_fall  (fall)
  );

  dpdw_interval #(.SET_W(W_SET), .PRE_W(W_PRE)) u_ival (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (dpd_enter),
    .run     (t_run),
    .limit   (setting_rb),
    .hit     (t_hit)
  );

  dpdw_state #(.SET_W(W_SET)) u_state (
    .clk       (clk),
    .rst_n     (rst_n),
    .enter     (dpd_enter),
    .setting   (wake_setting),
    .cfg_in    (cfg_next),
    .timer_hit (t_hit),
    .pin_fall  (fall),
    .asleep    (dpd_asleep),
    .wake      (wake_req),
    .f_pin     (flag_pin),
    .f_tmr     (flag_timer),
    .f_por     (flag_por),
    .rb        (setting_rb),
    .cfg_q     (cfg_cur)
  );

  assign pullup_off = cfg_cur.pull_off;
endmodule

// File: rtl/dpd_wake_ctrl_chk.sv
module dpd_wake_ctrl_chk #(
  parameter int unsigned W_SET = 14
) (
  input logic             clk,
  input logic             rst_n,
  input logic             dpd_enter,
  input logic [W_SET-1:0] wake_setting,
  input logic             wake_req,
  input logic             dpd_asleep,
  input logic             flag_pin,
  input logic             flag_timer,
  input logic             flag_por,
  input logic [W_SET-1:0] setting_rb,
  input logic             pullup_off
);
  // R2
  entry_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dpd_enter |=> (!wake_req && dpd_asleep && !flag_pin && !flag_timer && !flag_por));
  // R2
  rb_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dpd_enter |=> (setting_rb == $past(wake_setting)));
  // R2
  rb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dpd_enter |=> $stable(setting_rb));
  // R8
  wake_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_req && !dpd_enter) |=> wake_req);
  // R3
  wake_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wake_req) |-> ((flag_pin || flag_timer) && !dpd_asleep));
  // R7
  cause_with_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(flag_pin) || $rose(flag_timer)) |-> $rose(wake_req));
  // R9
  pullup_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dpd_enter |=> $stable(pullup_off));
  // R10
  por_no_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> !$rose(flag_por));
endmodule

bind dpd_wake_ctrl dpd_wake_ctrl_chk #(.W_SET(W_SET)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .dpd_enter    (dpd_enter),
  .wake_setting (wake_setting),
  .wake_req     (wake_req),
  .dpd_asleep   (dpd_asleep),
  .flag_pin     (flag_pin),
  .flag_timer   (flag_timer),
  .flag_por     (flag_por),
  .setting_rb   (setting_rb),
  .pullup_off   (pullup_off)
);

// File: tb/sim_dpd_wake_ctrl.sv
`timescale 1ns/1ps
module sim_dpd_wake_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dpd_enter = 1'b0;
  logic [13:0] wake_setting = '0;
  logic        timer_wake_en = 1'b0;
  logic        osc_off_in_dpd = 1'b0;
  logic        pin_wake_dis = 1'b1;
  logic        wake_pin = 1'b1;
  logic        pullup_sel_n = 1'b1;
  logic        wake_req, dpd_asleep, flag_pin, flag_timer, flag_por, pullup_off;
  logic [13:0] setting_rb;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  dpd_wake_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .dpd_enter(dpd_enter), .wake_setting(wake_setting),
    .timer_wake_en(timer_wake_en), .osc_off_in_dpd(osc_off_in_dpd),
    .pin_wake_dis(pin_wake_dis), .wake_pin(wake_pin), .pullup_sel_n(pullup_sel_n),
    .wake_req(wake_req), .dpd_asleep(dpd_asleep), .flag_pin(flag_pin),
    .flag_timer(flag_timer), .flag_por(flag_por), .setting_rb(setting_rb),
    .pullup_off(pullup_off)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // wait n edges, then sample 1 ns later
  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic enter_dpd();
    dpd_enter = 1'b1;
    edges(1);
    dpd_enter = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 wake", wake_req, 0);
    check("R1 asleep", dpd_asleep, 0);
    check("R1 flags", {flag_pin, flag_timer, flag_por}, 3'b001);
    check("R1 rb", setting_rb, 0);
    check("R1 pullup", pullup_off, 1);
  endtask

  task automatic t_timer(input int n);
    wake_setting = 14'(n); timer_wake_en = 1'b1; osc_off_in_dpd = 1'b0; pin_wake_dis = 1'b1;
    enter_dpd();
    check("R2 cleared", {wake_req, flag_pin, flag_timer, flag_por}, 0);
    check("R2 rb", setting_rb, 32'(n));
    wake_setting = 14'h1555;
    edges(64 * (n + 1) - 1);
    check("R3 early", wake_req, 0);
    edges(1);
    check("R3 on time", wake_req, 1);
    check("R3 flags", {flag_pin, flag_timer, flag_por, dpd_asleep}, 4'b0100);
    check("R2 rb held", setting_rb, 32'(n));
    edges(100);
    check("R8 sticky", wake_req, 1);
  endtask

  task automatic t_timer_off();
    wake_setting = 0; timer_wake_en = 1'b1; osc_off_in_dpd = 1'b1;
    enter_dpd();
    edges(300);
    check("R4 osc off", {wake_req, dpd_asleep}, 2'b01);
    osc_off_in_dpd = 1'b0; timer_wake_en = 1'b0;
    enter_dpd();
    edges(300);
    check("R4 en off", {wake_req, dpd_asleep}, 2'b01);
  endtask

  task automatic t_pin();
    timer_wake_en = 1'b0; pin_wake_dis = 1'b0;
    enter_dpd();
    edges(10);
    wake_pin = 1'b0;
    edges(2);
    check("R5 not yet", wake_req, 0);
    edges(1);
    check("R5 wake", {wake_req, flag_pin, flag_timer}, 3'b110);
    enter_dpd();
    edges(200);
    check("R6 held low", wake_req, 0);
    wake_pin = 1'b1;
    edges(5);
    pin_wake_dis = 1'b1;
    enter_dpd();
    wake_pin = 1'b0;
    edges(20);
    check("R6 disabled", {wake_req, flag_pin}, 2'b00);
    wake_pin = 1'b1;
    edges(5);
  endtask

  task automatic t_both();
    wake_setting = 0; timer_wake_en = 1'b1; pin_wake_dis = 1'b0;
    enter_dpd();
    edges(61);
    wake_pin = 1'b0;
    edges(2);
    check("R7 early", wake_req, 0);
    edges(1);
    check("R7 both", {wake_req, flag_pin, flag_timer}, 3'b111);
    wake_pin = 1'b1;
    edges(5);
  endtask

  task automatic t_pullup();
    pullup_sel_n = 1'b0; timer_wake_en = 1'b0; pin_wake_dis = 1'b1;
    check("R9 before", pullup_off, 1);
    enter_dpd();
    pullup_sel_n = 1'b1;
    edges(3);
    check("R9 latched", pullup_off, 0);
    wake_setting = 14'h3FFF;
    enter_dpd();
    check("R9 relatch", pullup_off, 1);
    check("R2 rb max", setting_rb, 14'h3FFF);
  endtask

  initial begin
    edges(3);
    t_reset();
    rst_n = 1'b1;
    edges(2);
    check("R10 por kept", flag_por, 1);
    t_timer(0);
    t_timer(2);
    t_timer_off();
    t_pin();
    t_both();
    t_pullup();
    check("R10 por clear", flag_por, 0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule